// File: doc/BRIEF.md
# SD Command Line Serializer with CRC7

This block sends one command frame on the command line of an SD card. A host writes a 32-bit word. The block drives that word onto the line most significant bit first, one bit for each SD clock. It then sends a 7-bit CRC of those 32 bits and a high stop bit, so a frame is exactly 40 clocks long. The SD clock is a one-cycle pulse made every `CLK_DIV` system cycles. The pulse is routed only to the card slot that `slot_sel` picks; every other slot sees no clock at all.

After the stop bit the block keeps clocking and watches the command line. It waits for the card to pull the line low, which marks the start of a response. A counter holds the number of SD clocks issued in the current access. If the line is still high once that count has reached a budget, a sticky timeout flag is set and clocking stops. A second sticky flag records CRC errors reported by an external response checker. A status read clears both flags. A write to byte 0 of the control register clears the CRC-error flag and sets the clock count back to zero.

Top module: `sd_cmd_serializer`

## Requirements
- R1: When `wr_stream` is sampled high while `busy` is low, the write is accepted. In the next cycle `busy` is 1 and `cmd_out` holds `wr_data[31]`. The line then moves to the next lower data bit in the cycle after each SD clock pulse, down to bit 0.
- R2: The seven bits after the data (bits 33 to 39 of the frame) are a CRC7 with polynomial x^7 + x^3 + 1. The register starts at zero, covers the 32 data bits in the order they were sent, and is sent MSB first.
- R3: Frame bit 40 is a stop bit of 1. `busy` falls in the cycle after the 40th clock pulse of the frame, and `cmd_out` is 1 whenever `busy` is low.
- R4: A `wr_stream` pulse sampled while `busy` is high is ignored: the frame in progress continues bit for bit and is not restarted.
- R5: While an access is active, an SD clock pulse occurs every `CLK_DIV` cycles, the first one `CLK_DIV` cycles after the write. Each pulse is bit n of `slot_clk` for `slot_sel` = n. No bit is pulsed when `slot_sel` ≥ `NSLOT`.
- R6: `clk_count` rises by one in the cycle of each clock pulse. An accepted stream write or a `ctl_byte0_wr` pulse sets it to 0 in the next cycle, and `ctl_byte0_wr` takes priority over a pulse.
- R7: After the frame, clocking continues. A low `cmd_in` sampled in the cycle after a pulse ends the access, with no timeout.
- R8: If `cmd_in` is high in the cycle after a pulse while `clk_count` ≥ `RESP_BUDGET`, `timeout_flag` is set and clocking stops.
- R9: A `stat_rd` pulse clears `timeout_flag` and `crc_err_flag` in the next cycle. A set in the same cycle wins over the clear.
- R10: A `resp_crc_bad` pulse sets `crc_err_flag`. A `ctl_byte0_wr` pulse clears it, and the set wins if both arrive in the same cycle.
- R11: A stream write while the block waits for a response is accepted and starts a new frame, with the count back at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stream | input | 1 | Stream register write strobe |
| wr_data | input | 32 | Command word to send |
| ctl_byte0_wr | input | 1 | Control register byte-0 write strobe |
| stat_rd | input | 1 | Status read strobe (clears flags) |
| slot_sel | input | SEL_W | Card slot that receives clocks |
| cmd_in | input | 1 | Sampled command line |
| resp_crc_bad | input | 1 | CRC error pulse from response checker |
| cmd_out | output | 1 | Command line drive value |
| busy | output | 1 | Frame being sent |
| slot_clk | output | NSLOT | Per-slot SD clock pulses |
| clk_count | output | CNT_W | SD clocks issued in this access |
| timeout_flag | output | 1 | Sticky response timeout |
| crc_err_flag | output | 1 | Sticky CRC error |

## Verification
The bench sends several words through the block:
- An all-zero word must give an all-zero CRC, so a stuck or mis-seeded CRC register shows up at once.
- An all-ones word and two mixed words exercise the feedback taps, and they expose a wrong bit order or an off-by-one in the data-to-CRC handover.
- One frame goes to a valid slot and one to an out-of-range slot. Together they show that the clock is gated per slot while the frame still runs.
- One access is left unanswered until the budget runs out, and others are answered early. This separates the timeout path from the response path.
- Writes arrive while a frame is busy and while the block waits for a response. These show which states accept a new frame.

// File: rtl/sdcs_pkg.sv
package sdcs_pkg;
  localparam int CMD_W     = 32;
  localparam int CRC_W     = 7;
  localparam int FRAME_LEN = CMD_W + CRC_W + 1;
  localparam int IDX_W     = $clog2(FRAME_LEN);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } sdcs_state_t;

  // one serial step of x^7 + x^3 + 1
  function automatic logic [CRC_W-1:0] crc7_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = b ^ c[CRC_W-1];
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction
endpackage

// File: rtl/sdcs_clk_gate.sv
module sdcs_clk_gate #(
  parameter int NSLOT   = 5,
  parameter int SEL_W   = 3,
  parameter int CLK_DIV = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [SEL_W-1:0] slot_sel,
  output logic             tick,
  output logic             adv,
  output logic [NSLOT-1:0] slot_clk
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [DIV_W-1:0] div_q;
  logic [NSLOT-1:0] slot_nx;

  assign tick = run && (div_q == DIV_W'(CLK_DIV-1));

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    assign slot_nx[i] = tick && (slot_sel == SEL_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst || restart || !run) begin
      div_q    <= '0;
      adv      <= 1'b0;
      slot_clk <= '0;
    end else begin
      div_q    <= tick ? '0 : div_q + 1'b1;
      adv      <= tick;
      slot_clk <= slot_nx;
    end
  end
endmodule

// File: rtl/sdcs_crc7.sv
module sdcs_crc7
  import sdcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             step,
  input  logic             bit_in,
  input  logic             shift,
  output logic [CRC_W-1:0] crc_q,
  output logic [CRC_W-1:0] crc_nx
);
  assign crc_nx = crc7_step(crc_q, bit_in);

  always_ff @(posedge clk) begin
    if (rst || clear)  crc_q <= '0;
    else if (step)     crc_q <= crc_nx;
    else if (shift)    crc_q <= {crc_q[CRC_W-2:0], 1'b0};
  end
endmodule

// File: rtl/sdcs_flags.sv
module sdcs_flags #(
  parameter int NFLAG = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NFLAG-1:0] set_i,
  input  logic [NFLAG-1:0] clr_i,
  output logic [NFLAG-1:0] flag_q
);
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)           flag_q[i] <= 1'b0;
      else if (set_i[i]) flag_q[i] <= 1'b1;
      else if (clr_i[i]) flag_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/sd_cmd_serializer.sv
module sd_cmd_serializer
  import sdcs_pkg::*;
#(
  parameter int NSLOT       = 5,
  parameter int SEL_W       = 3,
  parameter int CLK_DIV     = 2,
  parameter int RESP_BUDGET = 104,
  localparam int CNT_W      = $clog2(RESP_BUDGET + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_stream,
  input  logic [CMD_W-1:0] wr_data,
  input  logic             ctl_byte0_wr,
  input  logic             stat_rd,
  input  logic [SEL_W-1:0] slot_sel,
  input  logic             cmd_in,
  input  logic             resp_crc_bad,
  output logic             cmd_out,
  output logic             busy,
  output logic [NSLOT-1:0] slot_clk,
  output logic [CNT_W-1:0] clk_count,
  output logic             timeout_flag,
  output logic             crc_err_flag
);
  localparam logic [IDX_W-1:0] LAST_DATA = IDX_W'(CMD_W - 1);
  localparam logic [IDX_W-1:0] LAST_CRC  = IDX_W'(CMD_W + CRC_W - 1);
  localparam logic [IDX_W-1:0] LAST_BIT  = IDX_W'(FRAME_LEN - 1);

  sdcs_state_t      state;
  logic [CMD_W-2:0] shreg;
  logic [IDX_W-1:0] idx;
  logic             accept, adv_en, tick, adv, run;
  logic             crc_step, crc_shift, over_budget, set_to;
  logic [CRC_W-1:0] crc_q, crc_nx;
  logic [1:0]       flag_q;

  assign accept      = wr_stream && !busy;
  assign run         = (state != ST_IDLE);
  assign adv_en      = adv && !accept;
  assign over_budget = (clk_count >= CNT_W'(RESP_BUDGET));
  assign crc_step    = adv_en && (state == ST_SEND) && (idx <= LAST_DATA);
  assign crc_shift   = adv_en && (state == ST_SEND) && (idx > LAST_DATA) && (idx < LAST_CRC);
  assign set_to      = adv_en && (state == ST_WAIT) && cmd_in && over_budget;

  sdcs_clk_gate #(.NSLOT(NSLOT), .SEL_W(SEL_W), .CLK_DIV(CLK_DIV)) u_gate (
    .clk(clk), .rst(rst), .run(run), .restart(accept), .slot_sel(slot_sel),
    .tick(tick), .adv(adv), .slot_clk(slot_clk)
  );

  sdcs_crc7 u_crc (
    .clk(clk), .rst(rst), .clear(accept), .step(crc_step), .bit_in(cmd_out),
    .shift(crc_shift), .crc_q(crc_q), .crc_nx(crc_nx)
  );

  sdcs_flags #(.NFLAG(2)) u_flags (
    .clk(clk), .rst(rst),
    .set_i({resp_crc_bad, set_to}),
    .clr_i({stat_rd | ctl_byte0_wr, stat_rd}),
    .flag_q(flag_q)
  );
  assign timeout_flag = flag_q[0];
  assign crc_err_flag = flag_q[1];

  // frame sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      busy    <= 1'b0;
      cmd_out <= 1'b1;
      idx     <= '0;
      shreg   <= '0;
    end else if (accept) begin
      state   <= ST_SEND;
      busy    <= 1'b1;
      cmd_out <= wr_data[CMD_W-1];
      shreg   <= wr_data[CMD_W-2:0];
      idx     <= '0;
    end else if (adv_en) begin
      unique case (state)
        ST_SEND: begin
          if (idx == LAST_BIT) begin
            state   <= ST_WAIT;
            busy    <= 1'b0;
            cmd_out <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
            if (idx < LAST_DATA) begin
              cmd_out <= shreg[CMD_W-2];
              shreg   <= {shreg[CMD_W-3:0], 1'b0};
            end else if (idx == LAST_DATA) begin
              cmd_out <= crc_nx[CRC_W-1];
            end else if (idx < LAST_CRC) begin
              cmd_out <= crc_q[CRC_W-2];
            end else begin
              cmd_out <= 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (!cmd_in || over_budget) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // access clock counter
  always_ff @(posedge clk) begin
    if (rst || accept || ctl_byte0_wr) clk_count <= '0;
    else if (tick && clk_count != '1)  clk_count <= clk_count + 1'b1;
  end
endmodule

module sdcs_checker #(
  parameter int NSLOT = 5,
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_stream,
  input logic             ctl_byte0_wr,
  input logic             stat_rd,
  input logic             resp_crc_bad,
  input logic             cmd_out,
  input logic             busy,
  input logic [NSLOT-1:0] slot_clk,
  input logic [CNT_W-1:0] clk_count,
  input logic             timeout_flag,
  input logic             crc_err_flag
);
  // R1
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    wr_stream && !busy |=> busy);
  // R3
  idle_line_high_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> cmd_out);
  // R5
  one_slot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(slot_clk));
  // R6
  byte0_count_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_byte0_wr |=> clk_count == '0);
  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl_byte0_wr && !(wr_stream && !busy) |=> clk_count >= $past(clk_count));
  // R8
  timeout_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout_flag) |-> !busy);
  // R9
  read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    stat_rd && !resp_crc_bad |=> !crc_err_flag);
  // R10
  crc_set_chk: assert property (@(posedge clk) disable iff (rst)
    resp_crc_bad |=> crc_err_flag);
endmodule

bind sd_cmd_serializer sdcs_checker #(.NSLOT(NSLOT), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_stream(wr_stream), .ctl_byte0_wr(ctl_byte0_wr),
  .stat_rd(stat_rd), .resp_crc_bad(resp_crc_bad), .cmd_out(cmd_out), .busy(busy),
  .slot_clk(slot_clk), .clk_count(clk_count), .timeout_flag(timeout_flag),
  .crc_err_flag(crc_err_flag)
);

// File: tb/sd_cmd_serializer_test.sv
module sd_cmd_serializer_test;
  localparam int CLK_P   = 10;
  localparam int NSLOT   = 5;
  localparam int SEL_W   = 3;
  localparam int DIV     = 2;
  localparam int BUDGET  = 104;
  localparam int CNT_W   = $clog2(BUDGET + 1);

  logic clk = 0, rst = 1;
  logic wr_stream = 0, ctl_byte0_wr = 0, stat_rd = 0, cmd_in = 1, resp_crc_bad = 0;
  logic [31:0] wr_data = 0;
  logic [SEL_W-1:0] slot_sel = 0;
  logic cmd_out, busy, timeout_flag, crc_err_flag;
  logic [NSLOT-1:0] slot_clk;
  logic [CNT_W-1:0] clk_count;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  sd_cmd_serializer #(.NSLOT(NSLOT), .SEL_W(SEL_W), .CLK_DIV(DIV), .RESP_BUDGET(BUDGET)) uut (
    .clk(clk), .rst(rst), .wr_stream(wr_stream), .wr_data(wr_data),
    .ctl_byte0_wr(ctl_byte0_wr), .stat_rd(stat_rd), .slot_sel(slot_sel),
    .cmd_in(cmd_in), .resp_crc_bad(resp_crc_bad), .cmd_out(cmd_out), .busy(busy),
    .slot_clk(slot_clk), .clk_count(clk_count), .timeout_flag(timeout_flag),
    .crc_err_flag(crc_err_flag)
  );

  // reference model state
  bit m_busy, m_wait, m_adv, m_cmd, m_to, m_ce;
  int m_idx, m_div, m_cnt, m_clk;
  bit m_frame[40];

  task automatic build_frame(input logic [31:0] d);
    int c = 0;
    for (int k = 0; k < 32; k++) begin
      int b = d[31-k];
      int top = (c >> 6) & 1;
      c = (c << 1) & 8'h7f;
      if ((b ^ top) != 0) c = c ^ 9;
      m_frame[k] = d[31-k];
    end
    for (int k = 0; k < 7; k++) m_frame[32+k] = ((c >> (6-k)) & 1) != 0;
    m_frame[39] = 1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_busy = 0; m_wait = 0; m_adv = 0; m_cmd = 1; m_to = 0; m_ce = 0;
      m_idx = 0; m_div = 0; m_cnt = 0; m_clk = 0;
    end else begin
      bit act, tck, to_set;
      int old_cnt;
      to_set = 0;
      old_cnt = m_cnt;
      if (wr_stream && !m_busy) begin
        build_frame(wr_data);
        m_busy = 1; m_wait = 0; m_idx = 0; m_cmd = m_frame[0];
        m_cnt = 0; m_div = 0; m_adv = 0; m_clk = 0;
      end else begin
        act = m_busy || m_wait;
        tck = act && (m_div == DIV-1);
        if (m_adv) begin
          if (m_busy) begin
            if (m_idx == 39) begin m_busy = 0; m_wait = 1; m_cmd = 1; end
            else begin m_idx++; m_cmd = m_frame[m_idx]; end
          end else if (m_wait) begin
            if (!cmd_in) m_wait = 0;
            else if (old_cnt >= BUDGET) begin m_wait = 0; to_set = 1; end
          end
        end
        m_clk = (tck && slot_sel < NSLOT) ? (1 << slot_sel) : 0;
        m_adv = tck;
        m_div = !act ? 0 : (tck ? 0 : m_div + 1);
        if (tck) m_cnt = m_cnt + 1;
      end
      if (ctl_byte0_wr) m_cnt = 0;
      if (to_set) m_to = 1; else if (stat_rd) m_to = 0;
      if (resp_crc_bad) m_ce = 1; else if (stat_rd || ctl_byte0_wr) m_ce = 0;
    end
    #(CLK_P/4);
    if (!done) begin
      chk("R1 R2 R3 cmd_out", cmd_out, m_cmd);
      chk("R3 R4 busy", busy, m_busy);
      chk("R5 slot_clk", slot_clk, m_clk);
      chk("R6 clk_count", clk_count, m_cnt);
      chk("R8 R9 timeout_flag", timeout_flag, m_to);
      chk("R9 R10 crc_err_flag", crc_err_flag, m_ce);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic send(input logic [31:0] d);
    @(negedge clk); wr_stream = 1; wr_data = d;
    @(negedge clk); wr_stream = 0;
  endtask
  task automatic pulse_b0();
    @(negedge clk); ctl_byte0_wr = 1; @(negedge clk); ctl_byte0_wr = 0;
  endtask
  task automatic pulse_rd();
    @(negedge clk); stat_rd = 1; @(negedge clk); stat_rd = 0;
  endtask
  task automatic pulse_bad();
    @(negedge clk); resp_crc_bad = 1; @(negedge clk); resp_crc_bad = 0;
  endtask
  task automatic answer_after(input int n);
    idle(n); cmd_in = 0; idle(6); cmd_in = 1;
  endtask

  initial begin
    idle(3); rst = 0; idle(2);
    // reset state
    chk("R3 reset busy", busy, 0);
    chk("R6 reset count", clk_count, 0);
    // all-zero word, slot 0, no answer: timeout (R2, R8)
    slot_sel = 0; send(32'h0000_0000);
    idle(2 * BUDGET + 20);
    chk("R8 timeout set", timeout_flag, 1);
    pulse_rd(); idle(1);
    chk("R9 timeout cleared", timeout_flag, 0);
    // all-ones word, slot 2, ignored write while busy (R4), answered (R7)
    slot_sel = 2; send(32'hFFFF_FFFF);
    idle(10); send(32'h1234_5678);
    idle(80); answer_after(8);
    chk("R7 no timeout", timeout_flag, 0);
    // mixed word, slot 4, byte0 mid-frame, crc error flag handling (R6, R10)
    slot_sel = 4; send(32'hA5C3_0F1E);
    idle(21); pulse_b0(); idle(5); pulse_bad();
    chk("R10 crc err set", crc_err_flag, 1);
    pulse_b0();
    chk("R10 crc err cleared", crc_err_flag, 0);
    idle(60); answer_after(4);
    // invalid slot: frame runs without pulses (R5)
    slot_sel = 7; send(32'h4000_0000);
    idle(85);
    // write while waiting for response restarts the access (R11)
    slot_sel = 1; send(32'h8E21_7B3C);
    idle(90); answer_after(2);
    // simultaneous set and read-clear: set wins (R9)
    @(negedge clk); resp_crc_bad = 1; stat_rd = 1;
    @(negedge clk); resp_crc_bad = 0; stat_rd = 0;
    chk("R9 set wins", crc_err_flag, 1);
    pulse_rd(); idle(3);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule